// File: doc/BRIEF.md
# Interrupt-Controller Indirect CSR Access Checker

This block decides, in the same cycle as the decode, whether a CSR instruction that touches one of the advanced-interrupt CSRs must trap. It looks at the current privilege mode and virtualization bit, the targeted CSR (already decoded to a small code), the three indirect-select register values, the delegated supervisor external interrupt enable, the virtual-timer-injection control bit and the guest external interrupt number held in the hypervisor status register. It returns two flags: one for an illegal-instruction fault and one for a virtual-instruction fault.

The checker is pure combinational logic. The indirect-select values are classified against a fixed map of implemented indirect registers; the guest interrupt number is checked against a parameter giving the number of guest interrupt files. A pipeline stage upstream supplies the inputs and a trap unit downstream merges the two flags with the other CSR permission checks. Register contents and the interrupt files themselves live elsewhere.

Implemented indirect select values (the map used below): 0x30 to 0x3F, 0x70, 0x72 and 0x80 to 0xFF, where with `ODD_RESERVED` = 1 (default) the odd values in 0x30 to 0x3F and in 0x80 to 0xFF are not implemented. The guest-file set is 0x70, 0x72 and 0x80 to 0xFF under the same odd-value rule.

Top module: `intc_csr_gate`

## Requirements
- R1: When `csr_op` is 0 both `raise_illegal` and `raise_virtual` are 0, whatever the other inputs.
- R2: Mode encoding on `priv_mode`: 2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 reserved (never faults); HS is supervisor with `virt`=0, VS supervisor with `virt`=1, VU user with `virt`=1. An access to target code 1 (machine indirect data) in machine mode raises illegal exactly when `m_sel` is outside the implemented map.
- R3: An access to target code 2 (supervisor indirect data) in machine or HS mode raises illegal when `s_sel` is outside the implemented map.
- R4: In HS mode with `seie_deleg`=1, an access to target code 2 raises illegal when `s_sel` lies in 0x70 to 0xFF inclusive.
- R5: In VS mode an access to target code 2 raises illegal when `vs_sel` exceeds 0x1FF, raises virtual when `vs_sel` is in 0x30 to 0x3F or is odd in 0x80 to 0xFF, and raises nothing otherwise.
- R6: Any access to target code 2 from VU mode raises virtual.
- R7: An access to target code 3 (guest indirect data) in machine or HS mode raises illegal when `vs_sel` is outside the guest-file set.
- R8: The guest number `guest_id` is valid only when it is nonzero and not above `NUM_GUEST_FILES`; an access to target code 5 (guest top interrupt) in machine or HS mode raises illegal when it is invalid.
- R9: An access to target code 4 (supervisor top interrupt) raises illegal in HS mode when `seie_deleg`=1, and raises virtual in VS mode when `guest_id` is invalid.
- R10: In VS mode with `vti_on`=1, an access to target code 6 (supervisor pending) or 7 (supervisor enable) raises virtual.
- R11: The two outputs are never 1 together; any mode, target (code 0 = none) and input combination not named in R2 to R10 raises neither flag, and the flags follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_op | input | 1 | Instruction is a CSR access |
| priv_mode | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization mode active |
| target | input | 3 | Decoded target CSR code |
| m_sel | input | SEL_W | Machine indirect select value |
| s_sel | input | SEL_W | Supervisor indirect select value |
| vs_sel | input | SEL_W | Guest indirect select value |
| seie_deleg | input | 1 | Supervisor external interrupt enable delegated by machine level |
| vti_on | input | 1 | Virtual timer/interrupt injection control active |
| guest_id | input | GEI_W | Guest external interrupt number selected by the hypervisor |
| raise_illegal | output | 1 | Illegal-instruction fault |
| raise_virtual | output | 1 | Virtual-instruction fault |

## Verification
The block holds no state, so a fault in a select-range decoder or in the guest-number comparison shows at the flag outputs in the same evaluation as the offending input, with no delay to wait out. The risk lies at range edges (0x2F/0x30, 0x3F/0x40, 0x6F/0x70, 0x71/0x72, 0xFF/0x100, 0x1FF/0x200), at odd against even values and at the guest numbers 0, `NUM_GUEST_FILES` and one above it, so these are driven directly and the rest of the space is sampled at random against a reference model written from the requirements.

// File: rtl/intc_gate_pkg.sv
// Package: shared codes and the select-classification record for the
// interrupt-controller CSR access checker.
package intc_gate_pkg;

    // Decoded target CSR code supplied by the instruction decoder.
    typedef enum logic [2:0] {
        TGT_NONE     = 3'd0,
        TGT_M_DATA   = 3'd1,
        TGT_S_DATA   = 3'd2,
        TGT_G_DATA   = 3'd3,
        TGT_S_TOP    = 3'd4,
        TGT_G_TOP    = 3'd5,
        TGT_S_PEND   = 3'd6,
        TGT_S_ENABLE = 3'd7
    } target_e;

    // Privilege encoding on priv_mode.
    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

    // Classification of one indirect select value.
    typedef struct packed {
        logic implemented;  // in the implemented indirect map
        logic guest_impl;   // in the guest-file subset of the map
        logic prio_window;  // 0x30..0x3F
        logic ext_window;   // 0x70..0xFF
        logic odd_ext;      // odd value in 0x80..0xFF
        logic beyond_guest; // above 0x1FF
    } sel_class_t;

endpackage

// File: rtl/intc_sel_classify.sv
// Module: classifies one indirect select value against the fixed map of
// implemented indirect registers. ODD_RESERVED picks whether odd values in
// the priority and external windows are unimplemented (64-bit register
// layout) or implemented. Assumes SEL_W >= 10 so 0x1FF fits.
module intc_sel_classify
    import intc_gate_pkg::*;
#(
    parameter int SEL_W        = 12,
    parameter bit ODD_RESERVED = 1'b1
) (
    input  logic [SEL_W-1:0] sel_i,
    output sel_class_t       cls_o
);

    localparam logic [SEL_W-1:0] PRIO_LO  = SEL_W'(12'h030);
    localparam logic [SEL_W-1:0] PRIO_HI  = SEL_W'(12'h03F);
    localparam logic [SEL_W-1:0] DELIV    = SEL_W'(12'h070);
    localparam logic [SEL_W-1:0] THRESH   = SEL_W'(12'h072);
    localparam logic [SEL_W-1:0] EXT_LO   = SEL_W'(12'h070);
    localparam logic [SEL_W-1:0] BITS_LO  = SEL_W'(12'h080);
    localparam logic [SEL_W-1:0] BITS_HI  = SEL_W'(12'h0FF);
    localparam logic [SEL_W-1:0] GUEST_HI = SEL_W'(12'h1FF);

    logic in_prio, in_bits, is_odd, named_ext;
    logic prio_ok, bits_ok;

    // Window decode shared by both map variants.
    always_comb begin
        in_prio   = (sel_i >= PRIO_LO) && (sel_i <= PRIO_HI);
        in_bits   = (sel_i >= BITS_LO) && (sel_i <= BITS_HI);
        is_odd    = sel_i[0];
        named_ext = (sel_i == DELIV) || (sel_i == THRESH);
    end

    // Parameter-selected treatment of odd values inside the windows.
    generate
        if (ODD_RESERVED) begin : g_odd_hole
            always_comb begin
                prio_ok = in_prio && !is_odd;
                bits_ok = in_bits && !is_odd;
            end
        end else begin : g_odd_full
            always_comb begin
                prio_ok = in_prio;
                bits_ok = in_bits;
            end
        end
    endgenerate

    // Assemble the classification record.
    always_comb begin
        cls_o.guest_impl   = named_ext || bits_ok;
        cls_o.implemented  = prio_ok || named_ext || bits_ok;
        cls_o.prio_window  = in_prio;
        cls_o.ext_window   = (sel_i >= EXT_LO) && (sel_i <= BITS_HI);
        cls_o.odd_ext      = in_bits && is_odd;
        cls_o.beyond_guest = sel_i > GUEST_HI;
    end

    // Map consistency: an implemented value is never above the guest range.
    always_comb begin
        if (cls_o.implemented) begin
            assert_impl_below_limit_R2: assert (!cls_o.beyond_guest);
        end
        if (cls_o.odd_ext) begin
            assert_odd_inside_ext_R5: assert (cls_o.ext_window);
        end
    end

endmodule

// File: rtl/intc_guest_check.sv
// Module: decides whether a guest external interrupt number names an
// implemented guest interrupt file (1..NUM_GUEST_FILES).
// Assumes NUM_GUEST_FILES < 2**GEI_W.
module intc_guest_check #(
    parameter int GEI_W           = 6,
    parameter int NUM_GUEST_FILES = 5
) (
    input  logic [GEI_W-1:0] guest_id_i,
    output logic             valid_o
);

    localparam logic [GEI_W-1:0] LIMIT = GEI_W'(NUM_GUEST_FILES);

    // Range test against the configured file count.
    always_comb begin
        valid_o = (guest_id_i != '0) && (guest_id_i <= LIMIT);
    end

    // An invalid number is either zero or above the limit.
    always_comb begin
        if (!valid_o) begin
            assert_invalid_reason_R8: assert ((guest_id_i == '0) || (guest_id_i > LIMIT));
        end
    end

endmodule

// File: rtl/intc_fault_rules.sv
// Module: per-mode, per-target fault rules. Produces raw illegal and
// virtual requests from the select classifications and guest validity;
// gating and arbitration are done by the top.
module intc_fault_rules
    import intc_gate_pkg::*;
(
    input  logic [1:0]  priv_mode_i,
    input  logic        virt_i,
    input  target_e     target_i,
    input  sel_class_t  m_cls_i,
    input  sel_class_t  s_cls_i,
    input  sel_class_t  vs_cls_i,
    input  logic        seie_deleg_i,
    input  logic        vti_on_i,
    input  logic        guest_ok_i,
    output logic        ill_req_o,
    output logic        vir_req_o
);

    logic is_m, is_hs, is_vs, is_vu;

    // Effective mode decode.
    always_comb begin
        is_m  = (priv_mode_i == PRIV_MACH);
        is_hs = (priv_mode_i == PRIV_SUPER) && !virt_i;
        is_vs = (priv_mode_i == PRIV_SUPER) && virt_i;
        is_vu = (priv_mode_i == PRIV_USER)  && virt_i;
    end

    // Rule table per target CSR.
    always_comb begin
        ill_req_o = 1'b0;
        vir_req_o = 1'b0;
        unique case (target_i)
            TGT_M_DATA: begin
                ill_req_o = is_m && !m_cls_i.implemented;
            end
            TGT_S_DATA: begin
                if (is_m || is_hs) begin
                    ill_req_o = !s_cls_i.implemented
                              || (is_hs && seie_deleg_i && s_cls_i.ext_window);
                end else if (is_vs) begin
                    ill_req_o = vs_cls_i.beyond_guest;
                    vir_req_o = !vs_cls_i.beyond_guest
                              && (vs_cls_i.prio_window || vs_cls_i.odd_ext);
                end else if (is_vu) begin
                    vir_req_o = 1'b1;
                end
            end
            TGT_G_DATA: begin
                ill_req_o = (is_m || is_hs) && !vs_cls_i.guest_impl;
            end
            TGT_S_TOP: begin
                ill_req_o = is_hs && seie_deleg_i;
                vir_req_o = is_vs && !guest_ok_i;
            end
            TGT_G_TOP: begin
                ill_req_o = (is_m || is_hs) && !guest_ok_i;
            end
            TGT_S_PEND, TGT_S_ENABLE: begin
                vir_req_o = is_vs && vti_on_i;
            end
            default: begin
                ill_req_o = 1'b0;
                vir_req_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intc_csr_gate.sv
// Module: top of the interrupt-controller indirect CSR access checker.
// Classifies the three select values (one classifier per select, built by
// generate), checks the guest number, applies the fault rules, gates the
// result with csr_op and gives illegal precedence over virtual.
// Purely combinational; no clock or reset.
module intc_csr_gate
    import intc_gate_pkg::*;
#(
    parameter int SEL_W           = 12,
    parameter int GEI_W           = 6,
    parameter int NUM_GUEST_FILES = 5,
    parameter bit ODD_RESERVED    = 1'b1
) (
    input  logic             csr_op,
    input  logic [1:0]       priv_mode,
    input  logic             virt,
    input  logic [2:0]       target,
    input  logic [SEL_W-1:0] m_sel,
    input  logic [SEL_W-1:0] s_sel,
    input  logic [SEL_W-1:0] vs_sel,
    input  logic             seie_deleg,
    input  logic             vti_on,
    input  logic [GEI_W-1:0] guest_id,
    output logic             raise_illegal,
    output logic             raise_virtual
);

    localparam int NUM_SEL = 3;

    logic [NUM_SEL-1:0][SEL_W-1:0] sel_vec;
    sel_class_t                    cls_vec [NUM_SEL];
    logic                          guest_ok;
    logic                          ill_req, vir_req;
    target_e                       tgt;

    // Bundle the select inputs for the classifier array.
    always_comb begin
        sel_vec[0] = m_sel;
        sel_vec[1] = s_sel;
        sel_vec[2] = vs_sel;
        tgt        = target_e'(target);
    end

    generate
        for (genvar i = 0; i < NUM_SEL; i++) begin : g_cls
            intc_sel_classify #(
                .SEL_W        (SEL_W),
                .ODD_RESERVED (ODD_RESERVED)
            ) u_cls (
                .sel_i (sel_vec[i]),
                .cls_o (cls_vec[i])
            );
        end
    endgenerate

    intc_guest_check #(
        .GEI_W           (GEI_W),
        .NUM_GUEST_FILES (NUM_GUEST_FILES)
    ) u_guest (
        .guest_id_i (guest_id),
        .valid_o    (guest_ok)
    );

    intc_fault_rules u_rules (
        .priv_mode_i  (priv_mode),
        .virt_i       (virt),
        .target_i     (tgt),
        .m_cls_i      (cls_vec[0]),
        .s_cls_i      (cls_vec[1]),
        .vs_cls_i     (cls_vec[2]),
        .seie_deleg_i (seie_deleg),
        .vti_on_i     (vti_on),
        .guest_ok_i   (guest_ok),
        .ill_req_o    (ill_req),
        .vir_req_o    (vir_req)
    );

    // Gate with csr_op; illegal wins over virtual.
    always_comb begin
        raise_illegal = csr_op && ill_req;
        raise_virtual = csr_op && vir_req && !ill_req;
    end

    // Output-level checks against the rule requirements.
    always_comb begin
        assert_flags_exclusive_R11: assert (!(raise_illegal && raise_virtual));
        if (!csr_op) begin
            assert_idle_quiet_R1: assert (!raise_illegal && !raise_virtual);
        end
        if (csr_op && priv_mode == PRIV_USER && virt && tgt == TGT_S_DATA) begin
            assert_vu_sdata_virtual_R6: assert (raise_virtual);
        end
        if (csr_op && priv_mode == PRIV_SUPER && !virt && seie_deleg && tgt == TGT_S_TOP) begin
            assert_hs_top_illegal_R9: assert (raise_illegal);
        end
        if (csr_op && priv_mode == PRIV_SUPER && virt && vti_on
            && (tgt == TGT_S_PEND || tgt == TGT_S_ENABLE)) begin
            assert_vs_pend_virtual_R10: assert (raise_virtual);
        end
    end

endmodule

// File: tb/intc_csr_gate_test.sv
// Bench: directed corner cases plus seeded random stimulus, compared with
// a reference model written from the requirements.
module intc_csr_gate_test;

    localparam int SEL_W = 12;
    localparam int GEI_W = 6;
    localparam int NGF   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_op;
    logic [1:0]       priv_mode;
    logic             virt;
    logic [2:0]       target;
    logic [SEL_W-1:0] m_sel, s_sel, vs_sel;
    logic             seie_deleg, vti_on;
    logic [GEI_W-1:0] guest_id;
    logic             raise_illegal, raise_virtual;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    intc_csr_gate #(.SEL_W(SEL_W), .GEI_W(GEI_W), .NUM_GUEST_FILES(NGF)) uut (
        .csr_op(csr_op), .priv_mode(priv_mode), .virt(virt), .target(target),
        .m_sel(m_sel), .s_sel(s_sel), .vs_sel(vs_sel),
        .seie_deleg(seie_deleg), .vti_on(vti_on), .guest_id(guest_id),
        .raise_illegal(raise_illegal), .raise_virtual(raise_virtual)
    );

    // Implemented map membership (requirement text, odd values reserved).
    function automatic bit in_map(int v);
        if (v >= 'h30 && v <= 'h3F) return (v % 2) == 0;
        if (v == 'h70 || v == 'h72) return 1;
        if (v >= 'h80 && v <= 'hFF) return (v % 2) == 0;
        return 0;
    endfunction

    function automatic bit in_guest_set(int v);
        if (v == 'h70 || v == 'h72) return 1;
        if (v >= 'h80 && v <= 'hFF) return (v % 2) == 0;
        return 0;
    endfunction

    // Reference model: returns {illegal, virtual}.
    function automatic logic [1:0] model(bit op, int pm, bit vt, int tg, int ms, int ss,
                                         int vs, bit se, bit vi, int gid);
        bit m, hs, vsm, vu, gok, il, vr;
        m = (pm == 3); hs = (pm == 1) && !vt; vsm = (pm == 1) && vt; vu = (pm == 0) && vt;
        gok = (gid >= 1) && (gid <= NGF);
        il = 0; vr = 0;
        if (!op) return 2'b00;
        case (tg)
            1: il = m && !in_map(ms);
            2: begin
                if (m || hs) begin
                    if (!in_map(ss)) il = 1;
                    if (hs && se && ss >= 'h70 && ss <= 'hFF) il = 1;
                end else if (vsm) begin
                    if (vs > 'h1FF) il = 1;
                    else if ((vs >= 'h30 && vs <= 'h3F) || (vs >= 'h80 && vs <= 'hFF && vs % 2 == 1)) vr = 1;
                end else if (vu) vr = 1;
            end
            3: il = (m || hs) && !in_guest_set(vs);
            4: begin
                if (hs && se) il = 1;
                else if (vsm && !gok) vr = 1;
            end
            5: il = (m || hs) && !gok;
            6, 7: vr = vsm && vi;
            default: ;
        endcase
        return {il, vr};
    endfunction

    function automatic string tag_of(bit op, int tg, int pm, bit vt);
        if (!op) return "R1";
        case (tg)
            1: return "R2";
            2: return (pm == 0 && vt) ? "R6" : (pm == 1 && vt) ? "R5" : "R3/R4";
            3: return "R7";
            4: return "R9";
            5: return "R8";
            6, 7: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(bit op, int pm, bit vt, int tg, int ms, int ss, int vs,
                         bit se, bit vi, int gid, string tag);
        logic [1:0] exp_v, got;
        @(negedge clk);
        csr_op = op; priv_mode = pm[1:0]; virt = vt; target = tg[2:0];
        m_sel = ms[SEL_W-1:0]; s_sel = ss[SEL_W-1:0]; vs_sel = vs[SEL_W-1:0];
        seie_deleg = se; vti_on = vi; guest_id = gid[GEI_W-1:0];
        #1;
        exp_v = model(op, pm, vt, tg, ms % (1 << SEL_W), ss % (1 << SEL_W),
                      vs % (1 << SEL_W), se, vi, gid % (1 << GEI_W));
        got = {raise_illegal, raise_virtual};
        n_checks++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: pm=%0d v=%0d tgt=%0d m=%h s=%h vs=%h se=%0d vti=%0d g=%0d got={ill,vir}=%b expected=%b",
                     tag, pm, vt, tg, ms, ss, vs, se, vi, gid, got, exp_v);
        end
        // R11: never both flags.
        n_checks++;
        if (got == 2'b11) begin
            n_fail++;
            $display("FAIL R11: both flags high, got=%b expected not 11", got);
        end
    endtask

    initial begin
        csr_op = 0; priv_mode = 0; virt = 0; target = 0; m_sel = 0; s_sel = 0; vs_sel = 0;
        seie_deleg = 0; vti_on = 0; guest_id = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle and quiet, even with fault-prone inputs.
        apply(0, 0, 1, 2, 0, 0, 'h300, 1, 1, 0, "R1");
        apply(0, 1, 0, 4, 0, 0, 0, 1, 0, 0, "R1");
        // R2: mireg edges.
        apply(1, 3, 0, 1, 'h2F, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'h30, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'h31, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'h72, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'h71, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'hFE, 0, 0, 0, 0, 1, "R2");
        apply(1, 3, 0, 1, 'h100, 0, 0, 0, 0, 1, "R2");
        apply(1, 1, 0, 1, 'h100, 0, 0, 0, 0, 1, "R11");
        // R3/R4: sireg in M and HS.
        apply(1, 3, 0, 2, 0, 'h40, 0, 0, 0, 1, "R3");
        apply(1, 1, 0, 2, 0, 'h3E, 0, 0, 0, 1, "R3");
        apply(1, 1, 0, 2, 0, 'h70, 0, 1, 0, 1, "R4");
        apply(1, 1, 0, 2, 0, 'h3E, 0, 1, 0, 1, "R4");
        apply(1, 3, 0, 2, 0, 'h70, 0, 1, 0, 1, "R4");
        // R5: VS sireg.
        apply(1, 1, 1, 2, 0, 0, 'h1FF, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h200, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h30, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h3F, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h81, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h80, 0, 0, 1, "R5");
        apply(1, 1, 1, 2, 0, 0, 'h101, 0, 0, 1, "R5");
        // R6: VU sireg.
        apply(1, 0, 1, 2, 0, 0, 'h80, 0, 0, 1, "R6");
        apply(1, 0, 0, 2, 0, 0, 'h80, 0, 0, 1, "R11");
        // R7: vsireg.
        apply(1, 1, 0, 3, 0, 0, 'h30, 0, 0, 1, "R7");
        apply(1, 3, 0, 3, 0, 0, 'h72, 0, 0, 1, "R7");
        // R8: guest number boundaries on vstopei.
        apply(1, 3, 0, 5, 0, 0, 0, 0, 0, 0, "R8");
        apply(1, 1, 0, 5, 0, 0, 0, 0, 0, NGF, "R8");
        apply(1, 1, 0, 5, 0, 0, 0, 0, 0, NGF + 1, "R8");
        // R9: stopei.
        apply(1, 1, 0, 4, 0, 0, 0, 1, 0, 0, "R9");
        apply(1, 1, 1, 4, 0, 0, 0, 0, 0, 0, "R9");
        apply(1, 1, 1, 4, 0, 0, 0, 0, 0, 1, "R9");
        apply(1, 3, 0, 4, 0, 0, 0, 1, 0, 0, "R9");
        // R10: sip/sie.
        apply(1, 1, 1, 6, 0, 0, 0, 0, 1, 1, "R10");
        apply(1, 1, 1, 7, 0, 0, 0, 0, 1, 1, "R10");
        apply(1, 1, 0, 7, 0, 0, 0, 0, 1, 1, "R10");
        apply(1, 2, 1, 2, 0, 0, 'h200, 1, 1, 0, "R11");
        // Random sweep.
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            int pm, tg, ms, ss, vs, gid;
            bit op, vt, se, vi;
            op = ($urandom % 8) != 0;
            pm = $urandom % 4; vt = $urandom % 2; tg = $urandom % 8;
            ms = ($urandom % 4 == 0) ? $urandom % 4096 : $urandom % 512;
            ss = ($urandom % 4 == 0) ? $urandom % 4096 : $urandom % 512;
            vs = ($urandom % 4 == 0) ? $urandom % 4096 : $urandom % 640;
            se = $urandom % 2; vi = $urandom % 2; gid = $urandom % 10;
            apply(op, pm, vt, tg, ms, ss, vs, se, vi, gid, tag_of(op, tg, pm, vt));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule